// File: doc/BRIEF.md
# Bit-Serial Split-Table Inner-Product FIR Filter

This block is a fixed-coefficient low-pass FIR filter that forms its output without multipliers. Each accepted 16-bit two's-complement sample enters a delay line of `NTAPS` stages. The filter then walks the stored samples one bit position per cycle, least significant bit first. In each cycle the taps are grouped in pairs. The two bits of a pair address a four-entry table that holds every sum of that pair's coefficients, and a multiplexer picks the entry. An adder tree totals the pair outputs. A single accumulator shifts each total to its bit weight and adds it in. The only exception is the sign-bit plane, whose weighted total is subtracted.

Upstream logic offers a sample with `in_valid` whenever `busy` is low. One sample yields one exact result after sixteen processing cycles. The result is marked by a one-cycle `out_valid` pulse and stays on `out_data` until the next result replaces it. The tap count is a parameter with two legal values, 4 and 8. Each value selects its own symmetric coefficient set.

Top module: `mux_da_fir`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `out_valid` are 0 and `out_data` is 0. The delay line starts with all samples zero.
- R2: A sample is taken on a rising edge where `in_valid` is 1 and `busy` is 0. `busy` is 1 from the following cycle.
- R3: Each result equals the exact integer sum over k of c[k]·x[n−k]. Here x[n] is the sample just taken, x[n−k] is the sample taken k acceptances earlier (zero before reset release), and c is the coefficient set in R8.
- R4: `out_valid` rises 16 rising edges after the accepting edge and lasts exactly one cycle. `busy` is 0 in that same cycle, so the next sample can be taken at the very next edge.
- R5: `in_valid` asserted while `busy` is 1 has no effect. No sample is taken, and neither the running result nor the later results change.
- R6: Samples at the two's-complement extremes (−32768 and 32767) give exact results. The sign-bit plane enters the sum with negative weight −2^15.
- R7: `out_data` keeps its value in every cycle where `out_valid` is 0.
- R8: Coefficients are signed integers with value c/32768. With NTAPS=4 the set is [5538, 10846, 10846, 5538]. With NTAPS=8 it is [−2708, 0, 6646, 12446, 12446, 6646, 0, −2708]. Index 0 multiplies the newest sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered this cycle |
| in_data | input | 16 | Two's-complement sample |
| busy | output | 1 | Filter is processing bit-planes; offers are ignored |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 16+16+clog2(NTAPS) | Signed inner-product result (35 bits at the default of 8 taps) |

## Verification
Every result is due exactly 16 rising edges after the edge that accepted its sample. For each sample, the bench counts falling edges from the one that follows that edge. It requires `busy` high and `out_valid` low through the fifteenth falling edge, and `out_valid` high with `busy` low at the sixteenth. At that point it compares the result bit for bit with a direct integer convolution over its own history of accepted samples. At the seventeenth falling edge it checks that the pulse has ended and that the value is held. Offers made during the busy window are placed several cycles clear of both ends of it, so any effect they have shows up in the result being formed and in the one that follows.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } da_state_e;

    typedef struct packed {
        logic      busy;
        logic      last;
    } da_step_t;

    // Symmetric low-pass sets, value = coefficient / 2^15, index 0 = newest sample.
    function automatic logic signed [COEF_W-1:0] tap_coef(input int ntaps, input int idx);
        int mirror;
        logic signed [COEF_W-1:0] val;
        val = '0;
        if (ntaps == 4) begin
            mirror = (idx < 2) ? idx : 3 - idx;
            case (mirror)
                0:       val = 16'sd5538;
                default: val = 16'sd10846;
            endcase
        end else begin
            mirror = (idx < 4) ? idx : 7 - idx;
            case (mirror)
                0:       val = -16'sd2708;
                1:       val = 16'sd0;
                2:       val = 16'sd6646;
                default: val = 16'sd12446;
            endcase
        end
        return val;
    endfunction

endpackage

// File: rtl/da_pair_table.sv
module da_pair_table #(
    parameter int                       COEF_W = 16,
    parameter logic signed [COEF_W-1:0] H_LO   = '0,
    parameter logic signed [COEF_W-1:0] H_HI   = '0
) (
    input  logic [1:0]          sel,
    output logic [COEF_W:0]     pair_sum
);
    localparam int PAIR_W = COEF_W + 1;

    logic signed [PAIR_W-1:0] entry [4];

    always_comb begin
        entry[0] = '0;
        entry[1] = PAIR_W'(H_LO);
        entry[2] = PAIR_W'(H_HI);
        entry[3] = PAIR_W'(H_LO) + PAIR_W'(H_HI);
    end

    assign pair_sum = entry[sel];

endmodule

// File: rtl/da_adder_tree.sv
module da_adder_tree #(
    parameter int NPAIR = 4,
    parameter int IN_W  = 17,
    parameter int OUT_W = 19
) (
    input  logic [NPAIR-1:0][IN_W-1:0] terms,
    output logic [OUT_W-1:0]           total
);
    localparam int LEVELS = (NPAIR > 1) ? $clog2(NPAIR) : 1;
    localparam int SLOTS  = 1 << LEVELS;

    logic signed [OUT_W-1:0] node [LEVELS+1][SLOTS];

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            if (i < NPAIR) begin
                node[0][i] = OUT_W'($signed(terms[i]));
            end else begin
                node[0][i] = '0;
            end
        end
        for (int l = 1; l <= LEVELS; l++) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (i < (SLOTS >> l)) begin
                    node[l][i] = node[l-1][2*i] + node[l-1][2*i+1];
                end else begin
                    node[l][i] = '0;
                end
            end
        end
    end

    assign total = node[LEVELS][0];

endmodule

// File: rtl/da_ctrl.sv
module da_ctrl
    import fir_da_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output da_step_t         step,
    output logic [CNT_W-1:0] plane,
    output logic             done
);
    da_state_e        state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end
                end
                default: begin
                    if (cnt == CNT_W'(DATA_W - 1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign step.busy = (state == ST_RUN);
    assign step.last = (state == ST_RUN) && (cnt == CNT_W'(DATA_W - 1));
    assign plane     = cnt;

    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (rst)
        step.last |=> done);
    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_plane_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (step.busy && !step.last) |=> (step.busy && plane == $past(plane) + 1'b1));
    assert_start_plane0_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !step.busy) |=> (step.busy && plane == '0));

endmodule

// File: rtl/mux_da_fir.sv
module mux_da_fir
    import fir_da_pkg::*;
#(
    parameter int NTAPS  = 8,
    localparam int DATA_W = SAMPLE_W,
    localparam int NPAIR  = NTAPS / 2,
    localparam int PAIR_W = COEF_W + 1,
    localparam int PSUM_W = COEF_W + $clog2(NTAPS),
    localparam int ACC_W  = DATA_W + COEF_W + $clog2(NTAPS),
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              busy,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);
    initial begin
        if (NTAPS != 4 && NTAPS != 8) begin
            $error("NTAPS must be 4 or 8");
        end
    end

    logic [NTAPS-1:0][DATA_W-1:0] dline;
    da_step_t                     step;
    logic [CNT_W-1:0]             plane;
    logic                         done;
    logic                         accept;

    assign accept = in_valid && !step.busy;

    // Sample delay line, index 0 newest.
    always_ff @(posedge clk) begin
        if (rst) begin
            dline <= '0;
        end else if (accept) begin
            dline[0] <= in_data;
            for (int k = 1; k < NTAPS; k++) begin
                dline[k] <= dline[k-1];
            end
        end
    end

    da_ctrl #(.DATA_W(DATA_W)) i_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .step  (step),
        .plane (plane),
        .done  (done)
    );

    // Split tables: one four-entry table per coefficient pair.
    logic [NPAIR-1:0][PAIR_W-1:0] pair_out;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic [1:0] sel;
        assign sel = {dline[2*p+1][plane], dline[2*p][plane]};
        da_pair_table #(
            .COEF_W (COEF_W),
            .H_LO   (tap_coef(NTAPS, 2*p)),
            .H_HI   (tap_coef(NTAPS, 2*p+1))
        ) i_tab (
            .sel      (sel),
            .pair_sum (pair_out[p])
        );
    end

    logic [PSUM_W-1:0] plane_sum;

    da_adder_tree #(.NPAIR(NPAIR), .IN_W(PAIR_W), .OUT_W(PSUM_W)) i_tree (
        .terms (pair_out),
        .total (plane_sum)
    );

    // Single shift-accumulator; sign plane subtracts.
    logic signed [ACC_W-1:0] acc, acc_nxt, weighted;

    always_comb begin
        weighted = ACC_W'($signed(plane_sum)) <<< plane;
        acc_nxt  = step.last ? (acc - weighted) : (acc + weighted);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            out_data <= '0;
        end else if (accept) begin
            acc <= '0;
        end else if (step.busy) begin
            acc <= acc_nxt;
            if (step.last) begin
                out_data <= acc_nxt;
            end
        end
    end

    assign busy      = step.busy;
    assign out_valid = done;

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy) |=> busy);
    assert_line_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(dline));
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));
    assert_valid_idle_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !busy);

endmodule

// File: tb/test_mux_da_fir.sv
module test_mux_da_fir;

    localparam int NTAPS = 8;
    localparam int ACC_W = 16 + 16 + 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [15:0]      in_data = '0;
    logic             busy;
    logic             out_valid;
    logic [ACC_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    longint hist [NTAPS];

    always #4 clk = ~clk;

    mux_da_fir #(.NTAPS(NTAPS)) i_mux_da_fir (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .busy      (busy),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R8 coefficient set for 8 taps
    function automatic longint coef_r8(input int k);
        case (k)
            0, 7:    return -2708;
            1, 6:    return 0;
            2, 5:    return 6646;
            default: return 12446;
        endcase
    endfunction

    function automatic longint model_r3();
        longint s = 0;
        for (int k = 0; k < NTAPS; k++) s += coef_r8(k) * hist[k];
        return s;
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Offer one sample at a negedge with busy low; follow it to its result.
    task automatic send(input logic [15:0] d, input int gap, input bit inject);
        longint exp;
        repeat (gap) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'($signed(d));
        exp = model_r3();
        check("R2 busy after accept", longint'(busy), 1);
        for (int i = 1; i < 16; i++) begin
            if (inject && i == 4) begin
                in_valid = 1'b1;
                in_data  = ~d;
            end
            if (inject && i == 14) in_valid = 1'b0;
            @(negedge clk);
            if (out_valid !== 1'b0 || busy !== 1'b1) begin
                check("R4 early valid or idle", {out_valid, busy}, 2'b01);
            end
        end
        @(negedge clk);
        check("R4 valid at 16", longint'(out_valid), 1);
        check("R4 busy low with valid", longint'(busy), 0);
        check(inject ? "R5 result unaffected" : "R3 result", longint'($signed(out_data)), exp);
        @(negedge clk);
        check("R4 single pulse", longint'(out_valid), 0);
        check("R7 result held", longint'($signed(out_data)), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NTAPS; k++) hist[k] = 0;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", longint'(busy), 0);
        check("R1 valid in reset", longint'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", longint'(busy), 0);
        check("R1 valid after reset", longint'(out_valid), 0);
        check("R1 data after reset", longint'(out_data), 0);

        // R3/R8 impulse walks through every tap
        send(16'd1, 0, 1'b0);
        for (int k = 1; k < NTAPS; k++) send(16'd0, 0, 1'b0);
        // R6 extremes
        for (int k = 0; k < NTAPS; k++) send(16'h8000, 0, 1'b0);
        for (int k = 0; k < NTAPS; k++) send(16'h7FFF, 1, 1'b0);
        send(16'h8000, 0, 1'b0);
        send(16'h7FFF, 2, 1'b0);
        send(16'hFFFF, 0, 1'b0);
        // R5 offers during busy window
        send(16'h1234, 0, 1'b1);
        send(16'h8001, 0, 1'b1);
        send(16'h0055, 0, 1'b0);
        // random traffic
        for (int n = 0; n < 200; n++) begin
            send(16'($urandom), int'($urandom % 4), ($urandom % 5) == 0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule